// File: doc/BRIEF.md
# Pin Edge Interrupt Unit

This block watches a bank of general-purpose input pins and turns chosen signal transitions into interrupt requests. For every pin, software separately enables detection of low-to-high transitions, high-to-low transitions, or both. A detected transition sets that pin's bit in a sticky pending register. The bit stays set until software writes a one to it.

The low-numbered pins each drive their own request line. The remaining pins share one combined request. A per-pin wake mask turns any pending transition on a masked pin into a wake request. Pin inputs pass through a two-stage synchronizer before detection. Software uses a small word-addressed register port, with writes taking effect on the clock edge and read data driven combinationally from the address.

Top module: `pin_edge_irq`

## Requirements
- R1: After reset, the rise-enable, fall-enable, pending and wake-mask registers all read 0, and every request output is low.
- R2: A pin whose rise-enable bit is 1 sets its pending bit on a 0-to-1 transition of the synchronized pin.
- R3: A pin whose fall-enable bit is 1 sets its pending bit on a 1-to-0 transition of the synchronized pin.
- R4: A pin with both enable bits set catches either transition. A pin with neither bit set never sets its pending bit.
- R5: A pending bit stays at 1 until a write to the pending register carries a 1 in that bit position. Writing 0 to a bit leaves it unchanged, and writing all ones clears every pending bit.
- R6: If a new transition and a clearing write hit the same pending bit in the same cycle, the bit stays at 1.
- R7: directIrq[i] equals pending bit i for each pin i from 0 to 10.
- R8: sharedIrq is the OR of pending bits 11 to 27.
- R9: wakeReq is high exactly when some pin has both its wake-mask bit and its pending bit at 1.
- R10: Register map, by word address: 0 = synchronized pin levels (read-only, writes have no effect), 1 = rise enable, 2 = fall enable, 3 = pending (write ones to clear), 4 = wake mask. Bits 31..28 and every other address read 0.
- R11: A pin change driven before clock edge A shows in the level register after edge A+1 and in the pending register after edge A+2, not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pinIn | input | 28 | Asynchronous pin inputs |
| regAddr | input | 3 | Register word address |
| regWe | input | 1 | Write strobe, sampled on the clock edge |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for regAddr |
| directIrq | output | 11 | Per-pin requests for pins 0 to 10 |
| sharedIrq | output | 1 | Combined request for pins 11 to 27 |
| wakeReq | output | 1 | Wake request |

## Verification
The hardest case to reach is a transition that lands in the same cycle as a clearing write to the same pending bit. From the ports, the transition has to be timed two synchronizer cycles ahead. The stimulus first leaves two bits pending. It then raises one pin and issues a write that clears both bits, with the write timed to commit on the very edge where the synchronized transition is seen. Afterwards the raised pin's bit must still be set and the other bit must be clear. The bench also confirms that the pending register is still 0 one cycle before the transition appears, which pins down the latency.

// File: rtl/pin_edge_pkg.sv
package pin_edge_pkg;

  // Word offsets of the register map
  localparam int OFF_LEVEL = 0;
  localparam int OFF_RISE  = 1;
  localparam int OFF_FALL  = 2;
  localparam int OFF_PEND  = 3;
  localparam int OFF_WAKE  = 4;

  // Write strobes from control to datapath
  typedef struct packed {
    logic wrRise;
    logic wrFall;
    logic wrPend;
    logic wrWake;
  } regStrobe_t;

  // Read source selection
  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_LEVEL,
    SEL_RISE,
    SEL_FALL,
    SEL_PEND,
    SEL_WAKE
  } rdSel_e;

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int WIDTH  = 28,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stageQ [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : gStage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          stageQ[s] <= '0;
        end else if (s == 0) begin
          stageQ[s] <= asyncIn;
        end else begin
          stageQ[s] <= stageQ[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/edge_ctrl.sv
module edge_ctrl
  import pin_edge_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  output regStrobe_t        strobe,
  output rdSel_e            rdSel
);

  always_comb begin
    strobe        = '0;
    strobe.wrRise = regWe && (regAddr == ADDR_W'(OFF_RISE));
    strobe.wrFall = regWe && (regAddr == ADDR_W'(OFF_FALL));
    strobe.wrPend = regWe && (regAddr == ADDR_W'(OFF_PEND));
    strobe.wrWake = regWe && (regAddr == ADDR_W'(OFF_WAKE));
  end

  always_comb begin
    if (regAddr == ADDR_W'(OFF_LEVEL))      rdSel = SEL_LEVEL;
    else if (regAddr == ADDR_W'(OFF_RISE))  rdSel = SEL_RISE;
    else if (regAddr == ADDR_W'(OFF_FALL))  rdSel = SEL_FALL;
    else if (regAddr == ADDR_W'(OFF_PEND))  rdSel = SEL_PEND;
    else if (regAddr == ADDR_W'(OFF_WAKE))  rdSel = SEL_WAKE;
    else                                    rdSel = SEL_NONE;
  end

  // R10
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe));

endmodule

// File: rtl/edge_datapath.sv
module edge_datapath
  import pin_edge_pkg::*;
#(
  parameter int NUM_PINS   = 28,
  parameter int NUM_DIRECT = 11,
  parameter int DATA_W     = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_PINS-1:0]   pinSync,
  input  regStrobe_t            strobe,
  input  logic [NUM_PINS-1:0]   wrPins,
  input  rdSel_e                rdSel,
  output logic [DATA_W-1:0]     rdData,
  output logic [NUM_DIRECT-1:0] directIrq,
  output logic                  sharedIrq,
  output logic                  wakeReq
);

  logic [NUM_PINS-1:0] prevQ, riseQ, fallQ, pendQ, wakeQ;
  logic [NUM_PINS-1:0] edgeHit;
  logic [NUM_PINS-1:0] clrMask;

  // Per-pin transition detection
  generate
    for (genvar p = 0; p < NUM_PINS; p++) begin : gPin
      logic goesHigh, goesLow;
      assign goesHigh   = pinSync[p] & ~prevQ[p];
      assign goesLow    = ~pinSync[p] & prevQ[p];
      assign edgeHit[p] = (riseQ[p] & goesHigh) | (fallQ[p] & goesLow);
    end
  endgenerate

  assign clrMask = strobe.wrPend ? wrPins : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevQ <= '0;
      riseQ <= '0;
      fallQ <= '0;
      pendQ <= '0;
      wakeQ <= '0;
    end else begin
      prevQ <= pinSync;
      if (strobe.wrRise) riseQ <= wrPins;
      if (strobe.wrFall) fallQ <= wrPins;
      if (strobe.wrWake) wakeQ <= wrPins;
      // new transition has priority over a clearing write
      pendQ <= (pendQ & ~clrMask) | edgeHit;
    end
  end

  always_comb begin
    unique case (rdSel)
      SEL_LEVEL: rdData = DATA_W'(pinSync);
      SEL_RISE:  rdData = DATA_W'(riseQ);
      SEL_FALL:  rdData = DATA_W'(fallQ);
      SEL_PEND:  rdData = DATA_W'(pendQ);
      SEL_WAKE:  rdData = DATA_W'(wakeQ);
      default:   rdData = '0;
    endcase
  end

  assign directIrq = pendQ[NUM_DIRECT-1:0];
  assign sharedIrq = |pendQ[NUM_PINS-1:NUM_DIRECT];
  assign wakeReq   = |(pendQ & wakeQ);

  // R5
  sticky_pend_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrPend |=> ((pendQ & $past(pendQ)) == $past(pendQ)));

  // R6
  edge_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|edgeHit) |=> ((pendQ & $past(edgeHit)) == $past(edgeHit)));

  // R7
  generate
    for (genvar d = 0; d < NUM_DIRECT; d++) begin : gDirChk
      direct_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
        $rose(directIrq[d]) |-> $past(edgeHit[d]));
    end
  endgenerate

  // R8
  shared_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sharedIrq) |-> $past(|edgeHit[NUM_PINS-1:NUM_DIRECT]));

  // R9
  wake_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wakeReq) |-> ($past(|edgeHit) || $past(strobe.wrWake)));

  // R10
  enable_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.wrRise || strobe.wrFall) |=> ($stable(riseQ) && $stable(fallQ)));

endmodule

// File: rtl/pin_edge_irq.sv
module pin_edge_irq
  import pin_edge_pkg::*;
#(
  parameter int NUM_PINS    = 28,
  parameter int NUM_DIRECT  = 11,
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 32,  // must exceed NUM_PINS
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_PINS-1:0]   pinIn,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic                  regWe,
  input  logic [DATA_W-1:0]     regWdata,
  output logic [DATA_W-1:0]     regRdata,
  output logic [NUM_DIRECT-1:0] directIrq,
  output logic                  sharedIrq,
  output logic                  wakeReq
);

  logic [NUM_PINS-1:0] pinSync;
  regStrobe_t          strobe;
  rdSel_e              rdSel;
  logic                unusedWrHi;

  assign unusedWrHi = ^regWdata[DATA_W-1:NUM_PINS];

  pin_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) uSync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (pinIn),
    .syncOut (pinSync)
  );

  edge_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .regAddr (regAddr),
    .regWe   (regWe),
    .strobe  (strobe),
    .rdSel   (rdSel)
  );

  edge_datapath #(
    .NUM_PINS   (NUM_PINS),
    .NUM_DIRECT (NUM_DIRECT),
    .DATA_W     (DATA_W)
  ) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .pinSync   (pinSync),
    .strobe    (strobe),
    .wrPins    (regWdata[NUM_PINS-1:0]),
    .rdSel     (rdSel),
    .rdData    (regRdata),
    .directIrq (directIrq),
    .sharedIrq (sharedIrq),
    .wakeReq   (wakeReq)
  );

endmodule

// File: tb/tb_pin_edge_irq.sv
`timescale 1ns/1ps
module tb_pin_edge_irq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [27:0] pinIn = '0;
  logic [2:0]  regAddr = '0;
  logic        regWe = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [10:0] directIrq;
  logic        sharedIrq;
  logic        wakeReq;

  int nChecks = 0;
  int nFail   = 0;
  bit finished = 0;

  // scoreboard queues: kind 0 = register read, 1 = output snapshot
  logic [31:0] expQ  [$];
  bit          kindQ [$];
  string       tagQ  [$];

  always #10 clk = ~clk;  // 50 MHz

  pin_edge_irq dut (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .regAddr(regAddr),
    .regWe(regWe), .regWdata(regWdata), .regRdata(regRdata),
    .directIrq(directIrq), .sharedIrq(sharedIrq), .wakeReq(wakeReq)
  );

  // monitor: pops expected items and compares
  initial begin
    forever begin
      wait (expQ.size() > 0);
      #1;
      begin
        logic [31:0] exp, act;
        bit k;
        string t;
        exp = expQ.pop_front();
        k   = kindQ.pop_front();
        t   = tagQ.pop_front();
        act = k ? {19'd0, wakeReq, sharedIrq, directIrq} : regRdata;
        nChecks++;
        if (act !== exp) begin
          nFail++;
          $display("FAIL %s: actual %h expected %h", t, act, exp);
        end
      end
    end
  end

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic expectReg(input logic [2:0] a, input logic [31:0] e, input string t);
    regAddr = a;
    kindQ.push_back(1'b0); tagQ.push_back(t); expQ.push_back(e);
    @(negedge clk);
  endtask

  // expected {wakeReq, sharedIrq, directIrq}
  task automatic expectOut(input logic [31:0] e, input string t);
    kindQ.push_back(1'b1); tagQ.push_back(t); expQ.push_back(e);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(2);

    // R1 reset state
    expectReg(3'd1, 32'h0, "R1 rise");
    expectReg(3'd2, 32'h0, "R1 fall");
    expectReg(3'd3, 32'h0, "R1 pend");
    expectReg(3'd4, 32'h0, "R1 wake");
    expectOut(32'h0, "R1 outputs");

    // configure; R10 upper bits read 0
    regWrite(3'd1, 32'hF010_0021);
    regWrite(3'd2, 32'h0800_0022);
    regWrite(3'd4, 32'h0800_0008);
    expectReg(3'd1, 32'h0010_0021, "R10 rise readback");
    expectReg(3'd2, 32'h0800_0022, "R10 fall readback");
    expectReg(3'd4, 32'h0800_0008, "R10 wake readback");

    // R2 rising edges, R11 latency
    pinIn = 28'h810_002B;
    idle(2);
    expectReg(3'd3, 32'h0, "R11 pend not yet set");
    expectReg(3'd3, 32'h0010_0021, "R2 rising pend");
    expectOut(32'h821, "R7 R8 R9 after rising");
    expectReg(3'd0, 32'h0810_002B, "R10 level");

    // R3 falling edges, R4 both/none
    pinIn = '0;
    idle(3);
    expectReg(3'd3, 32'h0810_0023, "R3 R4 falling pend");
    expectOut(32'h1823, "R9 wake via pin27");

    // R5 write-one-to-clear
    regWrite(3'd3, 32'h0000_0020);
    expectReg(3'd3, 32'h0810_0003, "R5 clear bit5");
    regWrite(3'd3, 32'h0);
    expectReg(3'd3, 32'h0810_0003, "R5 zeros no effect");

    // R10 read-only level and unmapped offset
    regWrite(3'd0, 32'hFFFF_FFFF);
    expectReg(3'd0, 32'h0, "R10 level write ignored");
    expectReg(3'd3, 32'h0810_0003, "R10 level write no side effect");
    regWrite(3'd5, 32'hFFFF_FFFF);
    expectReg(3'd5, 32'h0, "R10 unmapped reads 0");

    // R8 shared drops when upper bits cleared
    regWrite(3'd3, 32'h0810_0000);
    expectOut(32'h003, "R8 shared cleared");

    // R6 collision: edge on pin0 with clear of bits 0 and 1
    pinIn = 28'h000_0001;
    idle(2);
    regWrite(3'd3, 32'h0000_0003);
    expectReg(3'd3, 32'h0000_0001, "R6 edge wins over clear");
    expectOut(32'h001, "R7 direct after collision");

    // R5 clear all
    regWrite(3'd3, 32'hFFFF_FFFF);
    expectReg(3'd3, 32'h0, "R5 clear all");
    expectOut(32'h0, "R7 R8 R9 all low");

    // R4 no enables: no detection
    regWrite(3'd1, 32'h0);
    regWrite(3'd2, 32'h0);
    pinIn = 28'hFFF_FFFF;
    idle(3);
    expectReg(3'd0, 32'h0FFF_FFFF, "R10 level all high");
    pinIn = '0;
    idle(4);
    expectReg(3'd3, 32'h0, "R4 disabled no pend");
    expectOut(32'h0, "R4 outputs low");

    wait (expQ.size() == 0);
    #2;
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule